// File: doc/BRIEF.md
# Conversion Result Sequencer with Wrap Override

This block steps a slot pointer through a bank of sixteen result registers and stores each incoming conversion result at the slot the pointer currently names. It runs in continuous mode. After a start pulse it accepts results until reset, with no further software action. A programmable maximum-conversion index sets the point where the pointer normally returns to slot zero. Each time the sequence boundary is reached, a sticky end-of-sequence flag is raised.

A single override bit stops the pointer from wrapping at the maximum index. With the override set, the pointer keeps counting through all sixteen registers and only wraps after the last one. The bank then acts as a linear capture buffer for results that arrive back to back. The end-of-sequence flag still marks the programmed boundary, and it also marks the end of the bank. A reset-sequencer pulse moves the pointer back to slot zero and leaves the stored results as they are.

Top module: `conv_seq_wrap`

## Requirements
- R1: After reset, the slot pointer is 0, the end-of-sequence flag is 0, every result register reads 0 and the sequencer is idle.
- R2: While the sequencer is idle (no start pulse since reset), `res_valid` has no effect: the pointer and all result registers keep their values.
- R3: When running, each cycle with `res_valid` high stores `res_data` into the register at the current pointer. Slot k occupies bits [k*12 +: 12] of `result_file`, and the new value is visible after that clock edge.
- R4: With `ovrd_en` low, each stored result advances the pointer by one. The pointer goes to 0 instead after the result is stored at the slot equal to `max_conv`, or at slot 15.
- R5: The flag becomes 1 after a result is stored at the slot equal to `max_conv` or at slot 15, in either mode. It stays 1 until a `flag_clr` pulse. If a set and a clear fall on the same edge, the set wins.
- R6: With `ovrd_en` high, the pointer does not wrap at `max_conv`. It advances by one after each stored result, and goes to 0 only after slot 15 has been written.
- R7: A `seq_reset` pulse sets the pointer to 0 and changes no result register. If a result is valid on the same edge, it is still stored at the old pointer.
- R8: Changes to `max_conv` or `ovrd_en` apply from the next pointer update. A pointer already above a lowered `max_conv` runs on to slot 15 and then wraps. With `max_conv` = 15 the two modes behave the same.
- R9: A `seq_start` pulse makes the sequencer run, and it keeps running (continuous mode) until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| seq_start | input | 1 | Pulse that starts continuous sequencing |
| seq_reset | input | 1 | Pulse that returns the slot pointer to 0 |
| ovrd_en | input | 1 | 1: run through all sixteen slots before wrapping |
| max_conv | input | 4 | Last slot of the programmed sequence |
| res_valid | input | 1 | Conversion result strobe |
| res_data | input | 12 | Conversion result value |
| flag_clr | input | 1 | Pulse that clears the end-of-sequence flag |
| result_file | output | 192 | Sixteen 12-bit result registers, slot k at [k*12 +: 12] |
| slot_ptr | output | 4 | Slot the next result will be written to |
| eos_flag | output | 1 | Sticky end-of-sequence flag |

## Verification
A wrong pointer shows on `slot_ptr` at the first clock edge after the wrong step. One result later, it also shows as data in the wrong slot of `result_file`. The bench compares pointer, flag and all sixteen slots against its model every cycle, so a wrong wrap, a missed override or a lost result is seen within one cycle. A wrong flag condition shows on `eos_flag` right after the boundary result is stored. Because the flag is sticky, the error stays visible until the next clear.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  // How the pointer moves on a given edge.
  typedef enum logic [1:0] {
    ADV_HOLD = 2'd0,
    ADV_STEP = 2'd1,
    ADV_WRAP = 2'd2,
    ADV_ZERO = 2'd3
  } adv_e;
endpackage

// File: rtl/cs_rst_sync.sv
module cs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cs_slot_ptr.sv
module cs_slot_ptr
  import conv_seq_pkg::*;
#(
  parameter int N_SLOT = 16,
  localparam int PTR_W = $clog2(N_SLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             seq_rst,
  input  logic             ovrd,
  input  logic [PTR_W-1:0] max_idx,
  output logic [PTR_W-1:0] ptr,
  output logic             bound_hit
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(N_SLOT - 1);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;
  logic             at_max;
  logic             at_last;
  adv_e             adv;

  always_comb begin
    at_max  = (ptr_q == max_idx);
    at_last = (ptr_q == LAST);
    if (seq_rst) begin
      adv = ADV_ZERO;
    end else if (!wr_en) begin
      adv = ADV_HOLD;
    end else if (at_last || (at_max && !ovrd)) begin
      adv = ADV_WRAP;
    end else begin
      adv = ADV_STEP;
    end
  end

  always_comb begin
    unique case (adv)
      ADV_STEP: ptr_d = ptr_q + 1'b1;
      ADV_WRAP: ptr_d = '0;
      ADV_ZERO: ptr_d = '0;
      default:  ptr_d = ptr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr       = ptr_q;
  assign bound_hit = wr_en && (at_max || at_last);
endmodule

// File: rtl/cs_result_bank.sv
module cs_result_bank #(
  parameter int N_SLOT = 16,
  parameter int DATA_W = 12,
  localparam int PTR_W = $clog2(N_SLOT)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [PTR_W-1:0]         wr_idx,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [N_SLOT*DATA_W-1:0] bank
);
  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    logic              slot_en;

    always_comb begin
      slot_en = wr_en && (wr_idx == PTR_W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_en) slot_q <= wr_data;
    end

    assign bank[g*DATA_W +: DATA_W] = slot_q;
  end
endmodule

// File: rtl/cs_eos_flag.sv
module cs_eos_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag
);
  logic flag_q;
  logic flag_d;

  always_comb begin
    if (set_i)      flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
    else            flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/conv_seq_wrap.sv
module conv_seq_wrap #(
  parameter int N_SLOT = 16,
  parameter int DATA_W = 12,
  localparam int PTR_W = $clog2(N_SLOT)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     seq_start,
  input  logic                     seq_reset,
  input  logic                     ovrd_en,
  input  logic [PTR_W-1:0]         max_conv,
  input  logic                     res_valid,
  input  logic [DATA_W-1:0]        res_data,
  input  logic                     flag_clr,
  output logic [N_SLOT*DATA_W-1:0] result_file,
  output logic [PTR_W-1:0]         slot_ptr,
  output logic                     eos_flag
);
  logic rst_s_n;
  logic running_q;
  logic running_d;
  logic wr_en;
  logic bound_hit;

  cs_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_s_n)
  );

  always_comb begin
    running_d = running_q | seq_start;
    wr_en     = running_q & res_valid;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) running_q <= 1'b0;
    else          running_q <= running_d;
  end

  cs_slot_ptr #(.N_SLOT(N_SLOT)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .wr_en     (wr_en),
    .seq_rst   (seq_reset),
    .ovrd      (ovrd_en),
    .max_idx   (max_conv),
    .ptr       (slot_ptr),
    .bound_hit (bound_hit)
  );

  cs_result_bank #(.N_SLOT(N_SLOT), .DATA_W(DATA_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .wr_en   (wr_en),
    .wr_idx  (slot_ptr),
    .wr_data (res_data),
    .bank    (result_file)
  );

  cs_eos_flag u_flag (
    .clk   (clk),
    .rst_n (rst_s_n),
    .set_i (bound_hit),
    .clr_i (flag_clr),
    .flag  (eos_flag)
  );
endmodule

// File: rtl/conv_seq_wrap_chk.sv
module conv_seq_wrap_chk #(
  parameter int N_SLOT = 16,
  localparam int PTR_W = $clog2(N_SLOT)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             seq_reset,
  input logic             ovrd_en,
  input logic [PTR_W-1:0] max_conv,
  input logic             res_valid,
  input logic             flag_clr,
  input logic [PTR_W-1:0] slot_ptr,
  input logic             eos_flag
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(N_SLOT - 1);

  // R2: idle or no result, and no sequencer reset: pointer holds
  p_ptr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(run && res_valid) && !seq_reset) |=> $stable(slot_ptr));

  // R4: normal mode steps by one below the boundary
  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && res_valid && !seq_reset && !ovrd_en && slot_ptr != max_conv && slot_ptr != LAST)
    |=> slot_ptr == PTR_W'($past(slot_ptr) + 1'b1));

  // R4: normal mode wraps at the programmed maximum
  p_wrap_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && res_valid && !ovrd_en && slot_ptr == max_conv) |=> slot_ptr == '0);

  // R6: override mode runs past the maximum until the last slot
  p_ovrd_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && res_valid && !seq_reset && ovrd_en && slot_ptr != LAST)
    |=> slot_ptr == PTR_W'($past(slot_ptr) + 1'b1));

  // R6: last slot always wraps
  p_last_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && res_valid && slot_ptr == LAST) |=> slot_ptr == '0);

  // R5: flag is sticky without a clear
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eos_flag && !flag_clr) |=> eos_flag);

  // R5: boundary result sets the flag even against a clear
  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && res_valid && (slot_ptr == max_conv || slot_ptr == LAST)) |=> eos_flag);

  // R7: sequencer reset returns the pointer to zero
  p_seqrst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_reset |=> slot_ptr == '0);
endmodule

bind conv_seq_wrap conv_seq_wrap_chk #(.N_SLOT(N_SLOT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_s_n),
  .run       (running_q),
  .seq_reset (seq_reset),
  .ovrd_en   (ovrd_en),
  .max_conv  (max_conv),
  .res_valid (res_valid),
  .flag_clr  (flag_clr),
  .slot_ptr  (slot_ptr),
  .eos_flag  (eos_flag)
);

// File: tb/tb_conv_seq_wrap.sv
`timescale 1ns/1ps
module tb_conv_seq_wrap;
  localparam int N  = 16;
  localparam int DW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seq_start = 0, seq_reset = 0, ovrd_en = 0, res_valid = 0, flag_clr = 0;
  logic [3:0] max_conv = 4'd7;
  logic [DW-1:0] res_data = '0;
  logic [N*DW-1:0] result_file;
  logic [3:0] slot_ptr;
  logic eos_flag;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  conv_seq_wrap dut (
    .clk(clk), .rst_n(rst_n), .seq_start(seq_start), .seq_reset(seq_reset),
    .ovrd_en(ovrd_en), .max_conv(max_conv), .res_valid(res_valid),
    .res_data(res_data), .flag_clr(flag_clr), .result_file(result_file),
    .slot_ptr(slot_ptr), .eos_flag(eos_flag)
  );

  // Behavioural reference
  int m_res [N];
  int m_ptr;
  bit m_flag;
  bit m_run;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_res[i]) m_res[i] = 0;
      m_ptr = 0; m_flag = 0; m_run = 0;
    end else begin
      int nxt;
      bit hit;
      nxt = m_ptr;
      hit = 0;
      if (m_run && res_valid) begin
        m_res[m_ptr] = res_data;
        hit = (m_ptr == max_conv) || (m_ptr == N-1);
        if (m_ptr == N-1 || (!ovrd_en && m_ptr == max_conv)) nxt = 0;
        else nxt = m_ptr + 1;
      end
      if (seq_reset) nxt = 0;
      if (hit) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      m_ptr = nxt;
      if (seq_start) m_run = 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      chk(slot_ptr == m_ptr[3:0], "R4/R6 pointer vs model", slot_ptr, m_ptr);
      chk(eos_flag == m_flag, "R5 flag vs model", eos_flag, m_flag);
      for (int k = 0; k < N; k++)
        chk(result_file[k*DW +: DW] == m_res[k][DW-1:0], "R3 slot vs model",
            result_file[k*DW +: DW], m_res[k]);
    end
  end

  function automatic int slot(input int k);
    return result_file[k*DW +: DW];
  endfunction

  task automatic drive(input bit v, input int d, input bit st, input bit sr, input bit cl);
    @(negedge clk);
    res_valid = v; res_data = DW'(d); seq_start = st; seq_reset = sr; flag_clr = cl;
  endtask

  task automatic settle();
    @(negedge clk);
    res_valid = 0; seq_start = 0; seq_reset = 0; flag_clr = 0;
  endtask

  task automatic push_n(input int n, input int base);
    for (int i = 0; i < n; i++) drive(1, base + i, 0, 0, 0);
    settle();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(slot_ptr == 0, "R1 pointer at reset", slot_ptr, 0);
    chk(eos_flag == 0, "R1 flag at reset", eos_flag, 0);
    chk(result_file == '0, "R1 bank at reset", slot(0), 0);

    // R2 results ignored while idle
    push_n(3, 12'h111);
    chk(slot_ptr == 0, "R2 pointer idle", slot_ptr, 0);
    chk(slot(0) == 0, "R2 slot0 idle", slot(0), 0);

    // R9 start, then continuous operation, normal mode max 7
    drive(0, 0, 1, 0, 0); settle();
    push_n(8, 12'h200);
    chk(slot_ptr == 0, "R4 wrap after max slot", slot_ptr, 0);
    chk(eos_flag == 1, "R5 flag at max slot", eos_flag, 1);
    chk(slot(7) == 12'h207, "R3 slot7 data", slot(7), 12'h207);
    push_n(3, 12'h300);
    chk(slot_ptr == 3, "R9 keeps running", slot_ptr, 3);
    chk(slot(0) == 12'h300, "R4 slot0 rewritten", slot(0), 12'h300);
    chk(eos_flag == 1, "R5 flag sticky", eos_flag, 1);
    drive(0, 0, 0, 0, 1); settle();
    chk(eos_flag == 0, "R5 flag cleared", eos_flag, 0);

    // R7 sequencer reset keeps results; override mode R6
    drive(0, 0, 0, 1, 0); settle();
    chk(slot_ptr == 0, "R7 pointer to zero", slot_ptr, 0);
    chk(slot(2) == 12'h302, "R7 results kept", slot(2), 12'h302);
    ovrd_en = 1;
    push_n(8, 12'h400);
    chk(slot_ptr == 8, "R6 no wrap at max", slot_ptr, 8);
    chk(eos_flag == 1, "R5 flag at max in override", eos_flag, 1);
    drive(0, 0, 0, 0, 1); settle();
    push_n(8, 12'h408);
    chk(slot_ptr == 0, "R6 wrap after slot 15", slot_ptr, 0);
    chk(slot(15) == 12'h40F, "R6 slot15 data", slot(15), 12'h40F);
    chk(eos_flag == 1, "R5 flag after slot 15", eos_flag, 1);

    // R5 set wins over clear on same edge
    push_n(7, 12'h500);
    drive(0, 0, 0, 0, 1); settle();
    drive(1, 12'h507, 0, 0, 1); settle();
    chk(eos_flag == 1, "R5 set beats clear", eos_flag, 1);

    // R7 reset with valid on same edge
    push_n(2, 12'h600);
    drive(1, 12'h6AA, 0, 1, 0); settle();
    chk(slot(10) == 12'h6AA, "R7 write at old pointer", slot(10), 12'h6AA);
    chk(slot_ptr == 0, "R7 pointer zero after combined", slot_ptr, 0);

    // R8 lowered max while pointer above it, normal mode
    ovrd_en = 0; max_conv = 4'd7;
    drive(0, 0, 0, 0, 1); settle();
    push_n(5, 12'h700);
    max_conv = 4'd3;
    push_n(2, 12'h710);
    chk(slot_ptr == 7, "R8 runs on past lowered max", slot_ptr, 7);
    drive(0, 0, 0, 0, 1); settle();
    push_n(9, 12'h720);
    chk(slot_ptr == 0, "R8 wraps at slot 15", slot_ptr, 0);
    chk(eos_flag == 1, "R8 flag at slot 15", eos_flag, 1);

    // R8 max 15: both modes identical
    max_conv = 4'd15;
    for (int m = 0; m < 2; m++) begin
      ovrd_en = m[0];
      drive(0, 0, 0, 1, 1); settle();
      push_n(15, 12'h800 + m * 16);
      chk(slot_ptr == 15, "R8 max15 no early wrap", slot_ptr, 15);
      chk(eos_flag == 0, "R8 max15 no early flag", eos_flag, 0);
      push_n(1, 12'h8F0);
      chk(slot_ptr == 0, "R8 max15 wrap", slot_ptr, 0);
    end

    // override toggled mid-sequence takes effect on next update
    max_conv = 4'd4; ovrd_en = 1;
    drive(0, 0, 0, 1, 1); settle();
    push_n(6, 12'h900);
    ovrd_en = 0;
    push_n(10, 12'h910);
    chk(slot_ptr == 0, "R8 override change applied", slot_ptr, 0);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule